// File: doc/BRIEF.md
# Indirect Pattern RAM Access Port

This block lets a host read and write a 40-bit-wide pattern RAM through two 32-bit registers. The data register holds bytes 0 to 3 of a RAM word. The control register holds three things: the RAM address, byte 4 of the word, and two one-shot command bits. A separate bank-select input picks which RAM bank a command uses. With the default parameters there are 2 banks of 128 words each.

A write command takes the data register together with the byte-4 field and the address field carried in the same control write, and stores them into one RAM word in a single clock. A read command fetches the addressed word. On the clock after the command, the word lands in the data register and the byte-4 field, where the host can then read it.

An input flag tells the block that the pattern-matching engine owns the RAM. While the flag is set, every command is dropped. Bit 31 of the control register always shows the flag, so software can poll it before starting an access.

The host interface is a registered read port. `host_sel` chooses which register to access. Register reads return the value that the selected register held before the clock edge.

Top module: `pmr_access_port`

## Requirements
- R1: Bit 31 of a control-register read equals `match_mode` as sampled at the clock edge that captured the read.
- R2: A control write with bit 30 set (write command) stores a 40-bit word into the RAM at {`bank_sel`, write-data bits 22:16}. Byte 4 of the stored word is write-data bits 7:0; bytes 0 to 3 are the data register as it was before that edge.
- R3: A control write with bit 29 set and bit 30 clear (read command) loads the addressed RAM word one clock edge later. Bytes 0 to 3 go to the data register and byte 4 goes to control bits 7:0.
- R4: Every control write stores write-data bits 22:16 as the address field and bits 7:0 as the byte-4 field. A control read returns them in those same bit positions.
- R5: Control reads return 0 in bits 30:29 (the command bits, which are write-only) and in bits 28:23 and 15:8 (reserved).
- R6: While `match_mode` is 1, both commands are ignored: the RAM is not written and the data register is not loaded.
- R7: A control write with both command bits set performs only the write command; no read load follows.
- R8: Words at the same address in different banks are independent of each other.
- R9: A synchronous reset (`rst` = 1) clears the address field to 0. The data register and the byte-4 field keep their contents.
- R10: `host_sel` = 0 selects the data register and `host_sel` = 1 selects the control register. `host_rdata` is registered and shows the selected register one edge after selection. A data-register write replaces all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| match_mode | input | 1 | Pattern-match engine owns the RAM; commands are refused |
| bank_sel | input | BANK_W | RAM bank used by a command |
| host_we | input | 1 | Register write strobe |
| host_sel | input | 1 | Register select: 0 selects data, 1 selects control |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Registered read data of the selected register |

## Verification
Most internal faults appear on the host port. A wrong RAM word, bank decode or load path shows up as a mismatch on the first read-back of the data register or the byte-4 field. That happens two edges after the read command: one edge for the RAM read and one for the load. A broken lockout or a broken write priority shows up the same way: the data register holds loaded contents instead of the value the host wrote. A bad field mask or a wrong mode mirror is visible on `host_rdata` one edge after the control register is selected.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
  localparam int REG_W      = 32;
  localparam int WORD_W     = 40;
  localparam int B4_W       = 8;
  localparam int MODE_BIT   = 31;
  localparam int WR_BIT     = 30;
  localparam int RD_BIT     = 29;
  localparam int ADDR_LSB   = 16;
  localparam int ADDR_FIELD = 7;
  localparam logic SEL_DATA = 1'b0;
  localparam logic SEL_CTRL = 1'b1;
endpackage

// File: rtl/pmr_ram.sv
module pmr_ram #(
  parameter int AW = 8,
  parameter int DW = 40
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/pmr_cmd.sv
module pmr_cmd (
  input  logic clk,
  input  logic rst,
  input  logic host_we,
  input  logic host_sel,
  input  logic wr_bit,
  input  logic rd_bit,
  input  logic match_mode,
  output logic ram_we,
  output logic ram_re,
  output logic load_v
);
  import pmr_pkg::*;
  logic ctrl_go;

  always_comb begin
    ctrl_go = host_we && (host_sel == SEL_CTRL) && !match_mode;
    ram_we  = ctrl_go && wr_bit;
    ram_re  = ctrl_go && rd_bit && !wr_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) load_v <= 1'b0;
    else     load_v <= ram_re;
  end

  // R7
  load_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    load_v |-> $past(ram_re) && !$past(ram_we));
endmodule

// File: rtl/pmr_regs.sv
module pmr_regs #(
  parameter int ADDR_W = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      host_we,
  input  logic                      host_sel,
  input  logic [31:0]               host_wdata,
  input  logic                      match_mode,
  input  logic                      load_v,
  input  logic [pmr_pkg::WORD_W-1:0] load_word,
  output logic [31:0]               data_q,
  output logic [7:0]                byte4_q,
  output logic [31:0]               host_rdata
);
  import pmr_pkg::*;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       ctrl_view;
  logic              wr_data, wr_ctrl;

  always_comb begin
    wr_data   = host_we && (host_sel == SEL_DATA);
    wr_ctrl   = host_we && (host_sel == SEL_CTRL);
    ctrl_view = '0;
    ctrl_view[MODE_BIT] = match_mode;
    ctrl_view[ADDR_LSB +: ADDR_W] = addr_q;
    ctrl_view[B4_W-1:0] = byte4_q;
  end

  // data bytes and byte 4 are never reset
  always_ff @(posedge clk) begin
    if (load_v) begin
      data_q  <= load_word[REG_W-1:0];
      byte4_q <= load_word[WORD_W-1:REG_W];
    end else begin
      if (wr_data) data_q  <= host_wdata;
      if (wr_ctrl) byte4_q <= host_wdata[B4_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          addr_q <= '0;
    else if (wr_ctrl) addr_q <= host_wdata[ADDR_LSB +: ADDR_W];
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= (host_sel == SEL_CTRL) ? ctrl_view : data_q;
  end

  // R3
  load_land_chk: assert property (@(posedge clk) disable iff (rst)
    load_v |=> (data_q == $past(load_word[31:0])) && (byte4_q == $past(load_word[39:32])));
  // R9
  addr_rst_chk: assert property (@(posedge clk)
    $past(rst) |-> addr_q == '0);
  // R5
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (host_sel == SEL_CTRL) |=> (host_rdata[30:23] == '0) && (host_rdata[15:8] == '0));
  // R1
  mode_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (host_sel == SEL_CTRL) |=> host_rdata[31] == $past(match_mode));
endmodule

// File: rtl/pmr_access_port.sv
module pmr_access_port #(
  parameter int ADDR_W = 7,
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              match_mode,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              host_we,
  input  logic              host_sel,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata
);
  import pmr_pkg::*;
  localparam int RAM_AW = ADDR_W + BANK_W;

  logic              ram_we, ram_re, load_v;
  logic [WORD_W-1:0] ram_q, ram_d;
  logic [RAM_AW-1:0] ram_a;
  logic [31:0]       data_q;
  logic [7:0]        byte4_q;
  logic              unused_bits;

  assign unused_bits = ^{host_wdata[31], host_wdata[28:23], host_wdata[15:8]};
  assign ram_a = {bank_sel, host_wdata[ADDR_LSB +: ADDR_W]};
  assign ram_d = {host_wdata[B4_W-1:0], data_q};

  pmr_cmd u_cmd (
    .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
    .wr_bit(host_wdata[WR_BIT]), .rd_bit(host_wdata[RD_BIT]),
    .match_mode(match_mode), .ram_we(ram_we), .ram_re(ram_re), .load_v(load_v)
  );

  pmr_ram #(.AW(RAM_AW), .DW(WORD_W)) u_ram (
    .clk(clk), .we(ram_we), .re(ram_re), .addr(ram_a), .wdata(ram_d), .rdata(ram_q)
  );

  pmr_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .match_mode(match_mode), .load_v(load_v),
    .load_word(ram_q), .data_q(data_q), .byte4_q(byte4_q), .host_rdata(host_rdata)
  );

  // R6
  lockout_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_we || ram_re) |-> !match_mode);
  // R2
  wr_word_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ram_d[39:32] == host_wdata[7:0]);
endmodule

// File: tb/tb_pmr_access_port.sv
module tb_pmr_access_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        match_mode = 1'b0;
  logic [0:0]  bank_sel = '0;
  logic        host_we = 1'b0;
  logic        host_sel = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  int tests = 0, fails = 0;
  logic [31:0] got;

  always #2.5 clk = ~clk;

  pmr_access_port dut (.*);

  // {bank, addr, byte4, data}
  localparam logic [47:0] VEC [6] = '{
    {1'b0, 7'h00, 8'hA5, 32'h1234_5678},
    {1'b1, 7'h00, 8'h5A, 32'h8765_4321},
    {1'b0, 7'h7F, 8'hFF, 32'hFFFF_FFFF},
    {1'b1, 7'h7F, 8'h00, 32'h0000_0000},
    {1'b0, 7'h2A, 8'h3C, 32'hDEAD_BEEF},
    {1'b1, 7'h55, 8'hC3, 32'h0F0F_F0F0}};

  function automatic logic [31:0] cw(input logic w, input logic r,
                                     input logic [6:0] a, input logic [7:0] b);
    return {1'b0, w, r, 6'b0, a, 8'b0, b};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] v);
    @(negedge clk); host_we = 1'b1; host_sel = sel; host_wdata = v;
    @(negedge clk); host_we = 1'b0; host_wdata = '0;
    @(negedge clk);
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    @(negedge clk); host_sel = sel;
    @(negedge clk); v = host_rdata;
  endtask

  task automatic ram_put(input logic bk, input logic [6:0] a, input logic [7:0] b,
                         input logic [31:0] d);
    bank_sel = bk; wr(1'b0, d); wr(1'b1, cw(1'b1, 1'b0, a, b));
  endtask

  task automatic ram_get(input logic bk, input logic [6:0] a);
    bank_sel = bk; wr(1'b1, cw(1'b0, 1'b1, a, 8'h00));
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 R5 reset state of control fields
    rd(1'b1, got); chk("R9", got & 32'hFFFF_FF00, 32'h0);

    // R2 R3 R8 R4 table: fill all, then read back each after clobbering
    foreach (VEC[i]) ram_put(VEC[i][47], VEC[i][46:40], VEC[i][39:32], VEC[i][31:0]);
    foreach (VEC[i]) begin
      wr(1'b0, 32'h0BAD_0BAD);
      wr(1'b1, 32'h0000_0011);
      ram_get(VEC[i][47], VEC[i][46:40]);
      rd(1'b0, got); chk("R3 R8 data", got, VEC[i][31:0]);
      rd(1'b1, got); chk("R2 R4 ctrl", got, {9'b0, VEC[i][46:40], 8'b0, VEC[i][39:32]});
    end

    // R10 data register full write and select
    wr(1'b0, 32'hC001_D00D); rd(1'b0, got); chk("R10", got, 32'hC001_D00D);

    // R1 R6 lockout
    match_mode = 1'b1;
    rd(1'b1, got); chk("R1", got[31], 1'b1);
    wr(1'b0, 32'h1111_2222);
    bank_sel = 1'b0; wr(1'b1, cw(1'b1, 1'b0, 7'h2A, 8'h99));
    ram_get(1'b0, 7'h2A);
    rd(1'b0, got); chk("R6 no load", got, 32'h1111_2222);
    match_mode = 1'b0;
    rd(1'b1, got); chk("R1 clear", got[31], 1'b0);
    ram_get(1'b0, 7'h2A);
    rd(1'b0, got); chk("R6 ram kept", got, 32'hDEAD_BEEF);
    rd(1'b1, got); chk("R6 b4 kept", got[7:0], 8'h3C);

    // R7 both commands: write wins, no load
    wr(1'b0, 32'h7777_8888);
    bank_sel = 1'b0; wr(1'b1, cw(1'b1, 1'b1, 7'h00, 8'h44));
    rd(1'b0, got); chk("R7 no load", got, 32'h7777_8888);
    wr(1'b0, 32'h0);
    ram_get(1'b0, 7'h00);
    rd(1'b0, got); chk("R7 stored", got, 32'h7777_8888);
    rd(1'b1, got); chk("R7 b4", got[7:0], 8'h44);

    // R5 command bits write-only
    wr(1'b1, 32'hFFFF_FFFF & ~32'h6000_0000 | 32'h2000_0000);
    rd(1'b1, got); chk("R5", got & 32'h7F80_FF00, 32'h0);

    // R9 reset keeps data and byte 4, clears addr
    wr(1'b0, 32'hABCD_EF01); wr(1'b1, cw(1'b0, 1'b0, 7'h33, 8'h5E));
    @(negedge clk); rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    rd(1'b1, got); chk("R9 ctrl", got, {24'h0, 8'h5E});
    rd(1'b0, got); chk("R9 data", got, 32'hABCD_EF01);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule